// File: doc/BRIEF.md
# Word-Addressed TLB Entry Array

This block is the software-managed storage behind a translation lookaside buffer. It holds 64 translation entries. Software reaches an entry one 32-bit word at a time through a single operation port. Each operation names an entry index, one of three word selects and a direction. Word 0 carries the virtual page tag, word 1 the physical page and word 2 the attribute and permission bits. A read returns the chosen word one cycle later, packed in the same layout a write uses. The block does no address lookup of its own.

The block also owns a 32-bit MMU control register. Its low byte is the process ID that a word-0 write copies into the entry. A word-0 read copies the entry's process ID back into that byte. Whenever a write alters a translation that is live, the block raises a one-cycle flush request. The translation caches downstream use it to drop stale copies. Page sizes are coded as 4-bit values: code n means 1 KB times 4 to the power n. Codes 0 to MAX_SIZE_CODE are legal.

Top module: `tlb_word_array`

## Requirements
- R1: After reset every entry is invalid and all other stored fields are zero. `flush_req`, `illegal_op`, `rd_valid` and `ctl_q` are all zero.
- R2: Only the low 6 bits of `op_index` select the entry. Higher bits have no effect.
- R3: The word-0 layout is: virtual page in bits 31:10, valid in bit 9, attribute bit in bit 8, size code in bits 7:4. Bits 3:0 read as zero. A read issued in cycle t shows `rd_valid` and `rd_data` after the next clock edge.
- R4: A word-0 write loads the entry's process ID from `ctl_q[7:0]`, taken before that edge. A word-0 read replaces `ctl_q[7:0]` with the entry's process ID and keeps `ctl_q[31:8]`.
- R5: A word-0 write to an entry that is already valid requests a flush in three cases: the virtual page changes, the decoded page size grows, or the valid bit is cleared. A write to an invalid entry never requests a flush. A write that only keeps or shrinks the size does not request one.
- R6: A size code above MAX_SIZE_CODE (9 by default) reads back as 1. It is treated as a 4 KB page in the grow comparison.
- R7: A word-1 write stores the data masked to bits 31:10 and 3:0. It requests a flush only if the entry is valid and the stored value changes.
- R8: A word-2 write stores attribute bits 15:8 and permission bits 5:0. Bits 0 to 2 are user read, write and execute. Bits 3 to 5 are supervisor read, write and execute. It leaves the valid bit and the word-0 attribute bit alone and never requests a flush. A word-2 read returns those bits in place, with all other bits zero.
- R9: Word select 3 pulses `illegal_op` for one cycle. It changes no entry, produces no read and requests no flush.
- R10: `flush_req` is registered. It is high only in the cycle after a write that caused it.
- R11: `ctl_wr_en` loads `ctl_wdata` into `ctl_q`. If a word-0 read happens in the same cycle, its process ID overrides the low byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation request this cycle |
| op_write | input | 1 | 1 = write, 0 = read |
| op_index | input | OPND_W | Index operand; the low 6 bits pick the entry |
| op_word | input | 2 | Word select 0, 1, 2 (3 is illegal) |
| op_wdata | input | 32 | Write data |
| ctl_wr_en | input | 1 | Load the MMU control register |
| ctl_wdata | input | 32 | Value for the MMU control register |
| ctl_q | output | 32 | MMU control register; bits 7:0 are the process ID |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 32 | Read result |
| flush_req | output | 1 | One-cycle translation flush request |
| illegal_op | output | 1 | One-cycle illegal word select flag |

## Verification
The bench uses the default parameters: 64 entries, a 32-bit index operand and a largest legal size code of 9. With these values, operand bits above bit 5 can be set to show that entries alias. Codes 10 to 15 also become available as out-of-range sizes. These codes allow cases where the raw-code comparison and the decoded-size comparison give opposite flush outcomes. A reference model tracks every entry. It predicts the read data, flush, illegal flag and control register for every cycle after reset.

// File: rtl/tlbw_pkg.sv
package tlbw_pkg;

    localparam int WORD_W  = 32;
    localparam int PID_W   = 8;
    localparam int VPAGE_W = 22;
    localparam int ATTR_W  = 8;
    localparam int PERM_W  = 6;

    // word-1 keeps page bits 31:10 and the low nibble
    localparam logic [WORD_W-1:0] PHYS_KEEP = 32'hFFFF_FC0F;

    typedef enum logic [1:0] {
        SEL_TAG  = 2'd0,
        SEL_PHYS = 2'd1,
        SEL_PERM = 2'd2,
        SEL_BAD  = 2'd3
    } word_sel_e;

    typedef struct packed {
        logic               valid;
        logic [VPAGE_W-1:0] vpage;
        logic [3:0]         szc;
        logic               attr0;
        logic [PID_W-1:0]   pid;
        logic [WORD_W-1:0]  phys;
        logic [ATTR_W-1:0]  attr_hi;
        logic [PERM_W-1:0]  perm;
    } entry_t;

    typedef struct packed {
        logic      wr;
        logic      rd;
        logic      bad;
        word_sel_e sel;
    } op_t;

    // out-of-range codes behave as code 1
    function automatic logic [3:0] eff_code(input logic [3:0] c, input logic [3:0] max_c);
        return (c > max_c) ? 4'd1 : c;
    endfunction

    // log2 of page size in bytes: 10 + 2*code
    function automatic logic [5:0] page_log2(input logic [3:0] c, input logic [3:0] max_c);
        logic [3:0] e;
        e = eff_code(c, max_c);
        return 6'd10 + {1'b0, e, 1'b0};
    endfunction

endpackage

// File: rtl/tlbw_opdec.sv
module tlbw_opdec
    import tlbw_pkg::*;
#(
    parameter int IDX_BITS = 6,
    parameter int OPND_W   = 32
) (
    input  logic                op_valid,
    input  logic                op_write,
    input  logic [OPND_W-1:0]   op_index,
    input  logic [1:0]          op_word,
    output op_t                 op,
    output logic [IDX_BITS-1:0] idx
);

    logic idx_unused;
    word_sel_e sel;

    assign sel        = word_sel_e'(op_word);
    assign idx        = op_index[IDX_BITS-1:0];
    assign idx_unused = ^op_index[OPND_W-1:IDX_BITS];

    always_comb begin
        op.sel = sel;
        op.bad = op_valid && (sel == SEL_BAD);
        op.wr  = op_valid && op_write  && (sel != SEL_BAD);
        op.rd  = op_valid && !op_write && (sel != SEL_BAD);
    end

endmodule

// File: rtl/tlbw_store.sv
module tlbw_store
    import tlbw_pkg::*;
#(
    parameter int IDX_BITS      = 6,
    parameter int MAX_SIZE_CODE = 9
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr,
    input  word_sel_e           sel,
    input  logic [IDX_BITS-1:0] idx,
    input  logic [WORD_W-1:0]   wdata,
    input  logic [PID_W-1:0]    pid_src,
    output entry_t              cur,
    output logic                flush_q
);

    localparam int ENTRIES = 1 << IDX_BITS;
    localparam logic [3:0] MAXC = 4'(MAX_SIZE_CODE);

    entry_t ent [ENTRIES];
    entry_t nxt;
    logic   need_flush;

    assign cur = ent[idx];

    always_comb begin
        nxt        = cur;
        need_flush = 1'b0;
        unique case (sel)
            SEL_TAG: begin
                nxt.vpage = wdata[31:10];
                nxt.valid = wdata[9];
                nxt.attr0 = wdata[8];
                nxt.szc   = wdata[7:4];
                nxt.pid   = pid_src;
                if (cur.valid) begin
                    if (nxt.vpage != cur.vpage)
                        need_flush = 1'b1;
                    if (page_log2(nxt.szc, MAXC) > page_log2(cur.szc, MAXC))
                        need_flush = 1'b1;
                    if (!nxt.valid)
                        need_flush = 1'b1;
                end
            end
            SEL_PHYS: begin
                nxt.phys = wdata & PHYS_KEEP;
                if (cur.valid && (nxt.phys != cur.phys))
                    need_flush = 1'b1;
            end
            SEL_PERM: begin
                nxt.attr_hi = wdata[15:8];
                nxt.perm    = wdata[5:0];
            end
            default: begin
            end
        endcase
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst)
                ent[g] <= '0;
            else if (wr && (idx == IDX_BITS'(g)))
                ent[g] <= nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            flush_q <= 1'b0;
        else
            flush_q <= wr && need_flush;
    end

endmodule

// File: rtl/tlbw_rdfmt.sv
module tlbw_rdfmt
    import tlbw_pkg::*;
#(
    parameter int MAX_SIZE_CODE = 9
) (
    input  entry_t            e,
    input  word_sel_e         sel,
    output logic [WORD_W-1:0] word,
    output logic [PID_W-1:0]  pid
);

    localparam logic [3:0] MAXC = 4'(MAX_SIZE_CODE);

    assign pid = e.pid;

    always_comb begin
        unique case (sel)
            SEL_TAG:  word = {e.vpage, e.valid, e.attr0, eff_code(e.szc, MAXC), 4'b0000};
            SEL_PHYS: word = e.phys;
            SEL_PERM: word = {16'h0000, e.attr_hi, 2'b00, e.perm};
            default:  word = '0;
        endcase
    end

endmodule

// File: rtl/tlb_word_array.sv
module tlb_word_array
    import tlbw_pkg::*;
#(
    parameter int IDX_BITS      = 6,
    parameter int OPND_W        = 32,
    parameter int MAX_SIZE_CODE = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic              op_write,
    input  logic [OPND_W-1:0] op_index,
    input  logic [1:0]        op_word,
    input  logic [31:0]       op_wdata,
    input  logic              ctl_wr_en,
    input  logic [31:0]       ctl_wdata,
    output logic [31:0]       ctl_q,
    output logic              rd_valid,
    output logic [31:0]       rd_data,
    output logic              flush_req,
    output logic              illegal_op
);

    op_t                 op;
    logic [IDX_BITS-1:0] idx;
    entry_t              cur;
    logic [WORD_W-1:0]   rd_word;
    logic [PID_W-1:0]    rd_pid;
    logic [WORD_W-1:0]   ctl_d;

    tlbw_opdec #(.IDX_BITS(IDX_BITS), .OPND_W(OPND_W)) u_dec (
        .op_valid (op_valid),
        .op_write (op_write),
        .op_index (op_index),
        .op_word  (op_word),
        .op       (op),
        .idx      (idx)
    );

    tlbw_store #(.IDX_BITS(IDX_BITS), .MAX_SIZE_CODE(MAX_SIZE_CODE)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr      (op.wr),
        .sel     (op.sel),
        .idx     (idx),
        .wdata   (op_wdata),
        .pid_src (ctl_q[PID_W-1:0]),
        .cur     (cur),
        .flush_q (flush_req)
    );

    tlbw_rdfmt #(.MAX_SIZE_CODE(MAX_SIZE_CODE)) u_fmt (
        .e    (cur),
        .sel  (op.sel),
        .word (rd_word),
        .pid  (rd_pid)
    );

    always_comb begin
        ctl_d = ctl_wr_en ? ctl_wdata : ctl_q;
        if (op.rd && (op.sel == SEL_TAG))
            ctl_d[PID_W-1:0] = rd_pid;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q      <= '0;
            rd_valid   <= 1'b0;
            rd_data    <= '0;
            illegal_op <= 1'b0;
        end else begin
            ctl_q      <= ctl_d;
            rd_valid   <= op.rd;
            rd_data    <= op.rd ? rd_word : '0;
            illegal_op <= op.bad;
        end
    end

endmodule

// File: rtl/tlbw_checker.sv
module tlbw_checker (
    input logic        clk,
    input logic        rst,
    input logic        op_valid,
    input logic        op_write,
    input logic [1:0]  op_word,
    input logic        ctl_wr_en,
    input logic [31:0] ctl_q,
    input logic        rd_valid,
    input logic [31:0] rd_data,
    input logic        flush_req,
    input logic        illegal_op
);

    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!flush_req && !rd_valid && !illegal_op));

    p_read_latency_r3: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !op_write && op_word != 2'd3) |=> rd_valid);

    p_ctl_high_kept_r4: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !op_write && op_word == 2'd0 && !ctl_wr_en) |=> (ctl_q[31:8] == $past(ctl_q[31:8])));

    p_phys_gap_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && $past(op_word) == 2'd1) |-> (rd_data[9:4] == 6'd0));

    p_perm_no_flush_r8: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_write && op_word == 2'd2) |=> !flush_req);

    p_perm_gaps_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && $past(op_word) == 2'd2) |-> (rd_data[31:16] == 16'd0 && rd_data[7:6] == 2'd0));

    p_bad_sel_r9: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_word == 2'd3) |=> (illegal_op && !rd_valid && !flush_req));

    p_illegal_cause_r9: assert property (@(posedge clk) disable iff (rst)
        illegal_op |-> $past(op_valid && op_word == 2'd3));

    p_flush_from_write_r10: assert property (@(posedge clk) disable iff (rst)
        flush_req |-> $past(op_valid && op_write && (op_word == 2'd0 || op_word == 2'd1)));

endmodule

bind tlb_word_array tlbw_checker u_chk (.*);

// File: tb/test_tlb_word_array.sv
module test_tlb_word_array;

    logic        clk = 1'b0;
    logic        rst;
    logic        op_valid, op_write, ctl_wr_en;
    logic [31:0] op_index, op_wdata, ctl_wdata;
    logic [1:0]  op_word;
    logic [31:0] ctl_q, rd_data;
    logic        rd_valid, flush_req, illegal_op;

    always #5 clk = ~clk;

    tlb_word_array i_tlb_word_array (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_write(op_write),
        .op_index(op_index), .op_word(op_word), .op_wdata(op_wdata),
        .ctl_wr_en(ctl_wr_en), .ctl_wdata(ctl_wdata), .ctl_q(ctl_q),
        .rd_valid(rd_valid), .rd_data(rd_data), .flush_req(flush_req),
        .illegal_op(illegal_op)
    );

    typedef struct packed {
        logic        rv;
        logic [31:0] rd;
        logic        fl;
        logic        il;
        logic [31:0] ctl;
    } exp_t;

    exp_t  q[$];
    string tq[$];
    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 0;

    // reference model
    logic        m_v   [64];
    logic [21:0] m_pg  [64];
    logic [3:0]  m_sz  [64];
    logic        m_a0  [64];
    logic [7:0]  m_pid [64];
    logic [31:0] m_ph  [64];
    logic [7:0]  m_ahi [64];
    logic [5:0]  m_pm  [64];
    logic [31:0] m_ctl;

    function automatic int sz_log(input logic [3:0] c);
        return (c > 4'd9) ? 12 : 10 + 2 * int'(c);
    endfunction

    function automatic logic [31:0] w0(input logic [21:0] pg, input logic v, input logic a, input logic [3:0] s);
        return {pg, v, a, s, 4'b0000};
    endfunction

    task automatic chk(input bit ok, input string tag, input string what, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
        end
    endtask

    task automatic op(input logic wr, input logic [31:0] index, input logic [1:0] w,
                      input logic [31:0] d, input logic cw, input logic [31:0] cd, input string tag);
        exp_t e;
        int   i;
        logic [31:0] nctl;
        @(negedge clk);
        i = int'(index[5:0]);
        e = '0;
        if (w == 2'd3) begin
            e.il = 1'b1;
        end else if (wr) begin
            if (w == 2'd0) begin
                if (m_v[i] && (d[31:10] != m_pg[i] || sz_log(d[7:4]) > sz_log(m_sz[i]) || !d[9]))
                    e.fl = 1'b1;
                m_pg[i] = d[31:10]; m_v[i] = d[9]; m_a0[i] = d[8]; m_sz[i] = d[7:4];
                m_pid[i] = m_ctl[7:0];
            end else if (w == 2'd1) begin
                if (m_v[i] && ((d & 32'hFFFF_FC0F) != m_ph[i])) e.fl = 1'b1;
                m_ph[i] = d & 32'hFFFF_FC0F;
            end else begin
                m_ahi[i] = d[15:8]; m_pm[i] = d[5:0];
            end
        end else begin
            e.rv = 1'b1;
            if (w == 2'd0)      e.rd = w0(m_pg[i], m_v[i], m_a0[i], (m_sz[i] > 4'd9) ? 4'd1 : m_sz[i]);
            else if (w == 2'd1) e.rd = m_ph[i];
            else                e.rd = {16'h0, m_ahi[i], 2'b00, m_pm[i]};
        end
        nctl = cw ? cd : m_ctl;
        if (!wr && w == 2'd0) nctl[7:0] = m_pid[i];
        m_ctl = nctl;
        e.ctl = nctl;
        op_valid = 1'b1; op_write = wr; op_index = index; op_word = w; op_wdata = d;
        ctl_wr_en = cw; ctl_wdata = cd;
        q.push_back(e); tq.push_back(tag);
    endtask

    task automatic idle(input string tag);
        exp_t e;
        @(negedge clk);
        op_valid = 1'b0; op_write = 1'b0; ctl_wr_en = 1'b0;
        e = '0; e.ctl = m_ctl;
        q.push_back(e); tq.push_back(tag);
    endtask

    task automatic wr(input logic [31:0] x, input logic [1:0] w, input logic [31:0] d, input string tag);
        op(1'b1, x, w, d, 1'b0, 32'h0, tag);
    endtask

    task automatic rd(input logic [31:0] x, input logic [1:0] w, input string tag);
        op(1'b0, x, w, 32'h0, 1'b0, 32'h0, tag);
    endtask

    task automatic cset(input logic [31:0] v, input string tag);
        exp_t e;
        @(negedge clk);
        op_valid = 1'b0; ctl_wr_en = 1'b1; ctl_wdata = v;
        m_ctl = v;
        e = '0; e.ctl = v;
        q.push_back(e); tq.push_back(tag);
    endtask

    // monitor: compare one expected item per cycle, away from the edge
    always @(posedge clk) begin
        #3;
        if (q.size() > 0) begin
            exp_t  e;
            string t;
            e = q.pop_front();
            t = tq.pop_front();
            chk(rd_valid == e.rv && (!e.rv || rd_data == e.rd), t, "read",
                {rd_data[31:1], rd_valid}, {e.rd[31:1], e.rv});
            chk(flush_req == e.fl, t, "flush", {31'h0, flush_req}, {31'h0, e.fl});
            chk(illegal_op == e.il, t, "illegal", {31'h0, illegal_op}, {31'h0, e.il});
            chk(ctl_q == e.ctl, t, "ctl", ctl_q, e.ctl);
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 64; k++) begin
            m_v[k] = 0; m_pg[k] = '0; m_sz[k] = '0; m_a0[k] = 0;
            m_pid[k] = '0; m_ph[k] = '0; m_ahi[k] = '0; m_pm[k] = '0;
        end
        m_ctl = '0;
        rst = 1'b1; op_valid = 0; op_write = 0; op_index = '0; op_word = '0;
        op_wdata = '0; ctl_wr_en = 0; ctl_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(0, 0, "R1"); rd(63, 0, "R1"); rd(5, 1, "R1"); rd(5, 2, "R1");
        idle("R1");

        // R3 layout, R11 control load
        cset(32'hDEAD_BE5A, "R11");
        wr(3, 0, w0(22'h12345, 1, 1, 3) | 32'h5, "R3");
        rd(3, 0, "R3");
        cset(32'h1111_1100, "R11");
        rd(3, 0, "R4");

        // R2 index aliasing
        rd(32'hFFFF_FFC3, 0, "R2");
        wr(32'h0000_0047, 0, w0(22'h0, 1, 0, 0), "R2");
        rd(32'h8000_0007, 0, "R2");
        rd(7, 0, "R2");

        // R5 flush cases on entry 3
        wr(3, 0, w0(22'h12345, 1, 1, 2), "R5");
        wr(3, 0, w0(22'h12345, 1, 0, 2), "R5");
        wr(3, 0, w0(22'h12345, 1, 0, 5), "R5");
        idle("R10");
        wr(3, 0, w0(22'h12346, 1, 0, 5), "R5");
        wr(3, 0, w0(22'h12346, 0, 0, 5), "R5");
        wr(3, 0, w0(22'h00001, 0, 0, 9), "R5");
        wr(3, 0, w0(22'h00001, 1, 1, 9), "R5");
        idle("R10");

        // R6 out-of-range size codes on entry 7
        wr(7, 0, w0(22'h0, 1, 0, 12), "R6");
        rd(7, 0, "R6");
        wr(7, 0, w0(22'h0, 1, 0, 10), "R6");
        wr(7, 0, w0(22'h0, 1, 0, 2), "R6");
        wr(7, 0, w0(22'h0, 1, 0, 13), "R6");
        rd(7, 0, "R6");

        // R7 physical word
        wr(3, 1, 32'hFFFF_FFFF, "R7");
        rd(3, 1, "R7");
        wr(3, 1, 32'hFFFF_FC0F, "R7");
        wr(3, 1, 32'hFFFF_FDFF, "R7");
        wr(3, 1, 32'h1234_5678, "R7");
        rd(3, 1, "R7");
        wr(20, 1, 32'hAAAA_AAAA, "R7");
        rd(20, 1, "R7");

        // R8 permission word
        wr(3, 2, 32'hFFFF_FFFF, "R8");
        rd(3, 2, "R8");
        rd(3, 0, "R8");
        wr(3, 2, 32'h0000_A52A, "R8");
        rd(3, 2, "R8");

        // R9 illegal select
        wr(3, 3, 32'h0000_0000, "R9");
        op(1'b0, 3, 3, 32'h0, 1'b0, 32'h0, "R9");
        rd(3, 0, "R9"); rd(3, 1, "R9"); rd(3, 2, "R9");

        // R4 process id on write, R11 concurrent control write
        cset(32'h0000_00C3, "R4");
        wr(9, 0, w0(22'h3FFFF, 1, 0, 1), "R4");
        cset(32'h0, "R4");
        rd(9, 0, "R4");
        op(1'b0, 7, 0, 32'h0, 1'b1, 32'hCAFE_F00D, "R11");
        idle("R10");
        idle("R10");

        while (q.size() > 0) @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule